// File: doc/BRIEF.md
# Single-Precision to 4-Bit Saturating Colour Converter

This unit executes one nonstandard instruction that lives in the floating-point major opcode space. The operand reaches the unit as the raw bit pattern of an IEEE-754 single-precision number held in an integer register. The unit turns that number into an unsigned integer clamped to 0..15 and hands it back for write-back into an integer register. The intended use is mapping floating-point colour intensities onto 4-bit device colour codes in one instruction.

The unit decodes each issued instruction word. When the word is not this instruction, the unit leaves the write-back port idle. When it is, the unit sorts the operand into a class: forced to zero, forced to the maximum, or rounded. A narrow shifter then rounds to nearest with ties to even, and a final clamp limits the result to 15. The `LATENCY` parameter selects a one-cycle or a two-cycle datapath.

Top module: `fcvt_sat4_unit`

## Requirements
- R1: `decodeHit` is high in the same cycle as `issueValid` if and only if the instruction word has bits 6:0 = 1010011, bits 31:25 = 1100001, bits 24:20 = 00000 and bits 14:12 = 000. An instruction with rd = x10 and rs1 = x11 therefore encodes as 0xC2058553.
- R2: For every accepted instruction, `wbEn` is high for exactly one cycle, `LATENCY` clock edges after the issue edge. In that cycle `wbRd` equals instruction bits 11:7.
- R3: An issue that is not accepted produces no `wbEn`, and `wbData` and `wbRd` keep their previous values.
- R4: Finite positive values that round to 16 or more, and positive infinity (0x7F800000), give 15.
- R5: Any operand with bit 31 set gives 0. This covers negative zero, negative numbers and negative infinity.
- R6: Any NaN (exponent field all ones with a nonzero fraction), of either sign, gives 0.
- R7: Positive zero and denormals (exponent field zero) give 0.
- R8: Non-integer values are rounded to the nearest integer, with ties going to the even neighbour, before the clamp. For example 0.5 gives 0, 1.5 gives 2, 2.5 gives 2 and 14.5 gives 14.
- R9: Exact integers 0 through 15 give their own value.
- R10: While reset is asserted and after it, until the first write-back, `wbEn`, `wbRd` and `wbData` are 0.
- R11: Accepted instructions issued on consecutive cycles each produce a write-back, in issue order, with no gaps.
- R12: Bits 31:4 of `wbData` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | An instruction is offered this cycle |
| instr | input | 32 | Instruction word |
| rs1Data | input | 32 | Source register value holding the float bit pattern |
| decodeHit | output | 1 | The offered instruction is this conversion and is accepted |
| wbEn | output | 1 | Destination register write enable |
| wbRd | output | 5 | Destination register index |
| wbData | output | 32 | Converted value, zero-extended |

## Verification
The bench goes after the rounding ties. A design that truncates would return 1 for 1.5. A design that rounds half up would return 3 for 2.5 and 15 for 14.5. It also drives values just above 15 that round past it, such as 15.5, to catch a clamp applied before rounding, which would return 15 too early or let the value wrap to 0. It drives negative zero, negative NaN, positive infinity and the largest denormal, which catch a sign test placed after the exponent test or a zero test that misses denormals. It offers words that differ from the encoding in one field only, which catch a decoder that ignores rs2 or funct3 and writes a register it should leave alone. It also issues back-to-back, which catches lost or reordered results.

// File: rtl/fsat4_pkg.sv
package fsat4_pkg;
  localparam int XLEN   = 32;
  localparam int EXP_W  = 8;
  localparam int MANT_W = 23;
  localparam int BIAS   = 127;

  localparam logic [6:0] OPC_OPFP = 7'b1010011;
  localparam logic [6:0] F7_SAT4  = 7'b1100001;
  localparam logic [4:0] RS2_SAT4 = 5'b00000;
  localparam logic [2:0] F3_SAT4  = 3'b000;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMid;
    logic loadOut;
  } strobe_t;

  typedef enum logic [1:0] {
    CLS_ZERO  = 2'd0,
    CLS_SAT   = 2'd1,
    CLS_ROUND = 2'd2
  } cls_e;
endpackage

// File: rtl/fsat4_ctrl.sv
module fsat4_ctrl
  import fsat4_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [XLEN-1:0] instr,
  output logic            decodeHit,
  output strobe_t         strb,
  output logic            wbEn,
  output logic [4:0]      wbRd
);
  logic [6:0] fOpc;
  logic [6:0] fF7;
  logic [4:0] fRs2;
  logic [2:0] fF3;
  logic [4:0] fRd;

  assign fOpc = instr[6:0];
  assign fRd  = instr[11:7];
  assign fF3  = instr[14:12];
  assign fRs2 = instr[24:20];
  assign fF7  = instr[31:25];

  assign decodeHit = issueValid && (fOpc == OPC_OPFP) && (fF7 == F7_SAT4)
                     && (fRs2 == RS2_SAT4) && (fF3 == F3_SAT4);

  // cycles since reset, for assertion warm-up only
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  generate
    if (LATENCY == 1) begin : g_lat1
      assign strb = '{loadMid: 1'b0, loadOut: decodeHit};
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wbEn <= 1'b0;
          wbRd <= '0;
        end else begin
          wbEn <= decodeHit;
          if (decodeHit) wbRd <= fRd;
        end
      end

      p_wb_after_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd1) |-> (wbEn == $past(decodeHit)));
      p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd1) && wbEn |-> (wbRd == $past(fRd)));
    end else begin : g_lat2
      logic       v1;
      logic [4:0] rd1;
      assign strb = '{loadMid: decodeHit, loadOut: v1};
      always_ff @(posedge clk) begin
        if (!rstN) begin
          v1   <= 1'b0;
          rd1  <= '0;
          wbEn <= 1'b0;
          wbRd <= '0;
        end else begin
          v1 <= decodeHit;
          if (decodeHit) rd1 <= fRd;
          wbEn <= v1;
          if (v1) wbRd <= rd1;
        end
      end

      p_wb_after_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2) |-> (wbEn == $past(decodeHit, 2)));
      p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2) && wbEn |-> (wbRd == $past(fRd, 2)));
    end
  endgenerate

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wbEn |=> (wbEn || $stable(wbRd)));
endmodule

// File: rtl/fsat4_datapath.sv
module fsat4_datapath
  import fsat4_pkg::*;
#(
  parameter int RES_W   = 4,
  parameter int LATENCY = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [XLEN-1:0] opData,
  output logic [XLEN-1:0] wbData
);
  localparam int SIG_W = MANT_W + 1;
  localparam int SH_W  = $clog2(SIG_W + 1);
  localparam int E_LO  = BIAS - 1;       // smallest exponent that can round up to 1
  localparam int E_SAT = BIAS + RES_W;   // value >= 2^RES_W from here on
  localparam logic [EXP_W-1:0] E_ALL   = '1;
  localparam logic [RES_W-1:0] RES_MAX = '1;

  typedef struct packed {
    cls_e             cls;
    logic [RES_W-1:0] intPart;
    logic             roundUp;
  } mid_t;

  logic              opSign;
  logic [EXP_W-1:0]  opExp;
  logic [MANT_W-1:0] opMant;
  assign opSign = opData[XLEN-1];
  assign opExp  = opData[XLEN-2 -: EXP_W];
  assign opMant = opData[MANT_W-1:0];

  // stage A: classification and alignment
  logic [SIG_W-1:0] sig, shifted, guardVec, lowMask;
  logic [SH_W-1:0]  shAmt, guardSh;
  logic             sticky;
  int               shInt;
  mid_t             midNow, midQ;

  always_comb begin
    sig      = {1'b1, opMant};
    shInt    = BIAS + MANT_W - int'(opExp);
    shAmt    = SH_W'(shInt);
    guardSh  = shAmt - SH_W'(1);
    shifted  = sig >> shAmt;
    guardVec = sig >> guardSh;
    lowMask  = (SIG_W'(1) << guardSh) - SIG_W'(1);
    sticky   = |(sig & lowMask);
    midNow   = '{cls: CLS_ZERO, intPart: '0, roundUp: 1'b0};
    if (opExp == E_ALL) begin
      midNow.cls = ((opMant != '0) || opSign) ? CLS_ZERO : CLS_SAT;
    end else if (opSign || (opExp == '0)) begin
      midNow.cls = CLS_ZERO;
    end else if (int'(opExp) >= E_SAT) begin
      midNow.cls = CLS_SAT;
    end else if (int'(opExp) >= E_LO) begin
      midNow.cls     = CLS_ROUND;
      midNow.intPart = shifted[RES_W-1:0];
      midNow.roundUp = guardVec[0] & (sticky | shifted[0]);
    end
  end

  generate
    if (LATENCY == 1) begin : g_comb
      assign midQ = midNow;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)             midQ <= '0;
        else if (strb.loadMid) midQ <= midNow;
      end
    end
  endgenerate

  // stage B: increment and clamp
  logic [RES_W:0]   sum;
  logic [RES_W-1:0] resNow;
  always_comb begin
    sum = {1'b0, midQ.intPart} + (RES_W+1)'(midQ.roundUp);
    unique case (midQ.cls)
      CLS_SAT:   resNow = RES_MAX;
      CLS_ROUND: resNow = sum[RES_W] ? RES_MAX : sum[RES_W-1:0];
      default:   resNow = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             wbData <= '0;
    else if (strb.loadOut) wbData <= XLEN'(resNow);
  end

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    wbData[XLEN-1:RES_W] == '0);
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOut |=> $stable(wbData));

  generate
    if (LATENCY == 1) begin : g_chk1
      p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
        strb.loadOut && opSign |=> (wbData == '0));
      p_inf_max_r4: assert property (@(posedge clk) disable iff (!rstN)
        strb.loadOut && !opSign && (opExp == E_ALL) && (opMant == '0)
        |=> (wbData == XLEN'(RES_MAX)));
    end else begin : g_chk2
      p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
        strb.loadMid && opSign |-> ##2 (wbData == '0));
      p_inf_max_r4: assert property (@(posedge clk) disable iff (!rstN)
        strb.loadMid && !opSign && (opExp == E_ALL) && (opMant == '0)
        |-> ##2 (wbData == XLEN'(RES_MAX)));
    end
  endgenerate
endmodule

// File: rtl/fcvt_sat4_unit.sv
module fcvt_sat4_unit
  import fsat4_pkg::*;
#(
  parameter int RES_W   = 4,
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [31:0] instr,
  input  logic [31:0] rs1Data,
  output logic        decodeHit,
  output logic        wbEn,
  output logic [4:0]  wbRd,
  output logic [31:0] wbData
);
  strobe_t strb;

  fsat4_ctrl #(.LATENCY(LATENCY)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .instr      (instr),
    .decodeHit  (decodeHit),
    .strb       (strb),
    .wbEn       (wbEn),
    .wbRd       (wbRd)
  );

  fsat4_datapath #(.RES_W(RES_W), .LATENCY(LATENCY)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opData (rs1Data),
    .wbData (wbData)
  );
endmodule

// File: tb/test_fcvt_sat4_unit.sv
`timescale 1ns/1ps
module test_fcvt_sat4_unit;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [31:0] instr, rs1Data;
  logic        decodeHit, wbEn;
  logic [4:0]  wbRd;
  logic [31:0] wbData;

  always #2.5 clk = ~clk;

  fcvt_sat4_unit #(.RES_W(4), .LATENCY(LAT)) i_fcvt_sat4_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
    .rs1Data(rs1Data), .decodeHit(decodeHit), .wbEn(wbEn), .wbRd(wbRd),
    .wbData(wbData)
  );

  typedef struct {
    logic [4:0] rd;
    logic [3:0] val;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  logic [31:0] lastData = '0;
  logic [4:0]  lastRd = '0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] rd, input logic [4:0] rs1);
    return {7'b1100001, 5'd0, rs1, 3'b000, rd, 7'b1010011};
  endfunction

  function automatic logic [31:0] toSingle(input real r);
    logic [63:0] d;
    d = $realtobits(r);
    return {d[63], 8'(int'(d[62:52]) - 896), d[51:29]};
  endfunction

  // independent reference built from the requirements
  function automatic logic [3:0] refConv(input logic [31:0] b);
    logic [63:0] dbl;
    real v, fl, rr;
    if (b[30:23] == 8'hFF && b[22:0] != 0) return 4'd0;  // R6
    if (b[31]) return 4'd0;                              // R5
    if (b[30:23] == 8'hFF) return 4'd15;                 // R4
    if (b[30:23] == 8'h00) return 4'd0;                  // R7
    dbl = {1'b0, 11'(int'(b[30:23]) + 896), b[22:0], 29'd0};
    v  = $bitstoreal(dbl);
    fl = $floor(v);
    rr = fl;
    if (v - fl > 0.5) rr = fl + 1.0;
    else if (v - fl == 0.5 && ($rtoi(fl) % 2 == 1)) rr = fl + 1.0;  // R8
    if (rr > 15.0) return 4'd15;
    return 4'($rtoi(rr));
  endfunction

  task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] op,
                       input bit expHit, input string tag);
    exp_t e;
    @(negedge clk);
    issueValid = v;
    instr      = ins;
    rs1Data    = op;
    #1;
    chk(decodeHit == expHit, "R1", "decodeHit", 32'(decodeHit), 32'(expHit));
    if (expHit) begin
      e.rd  = ins[11:7];
      e.val = refConv(op);
      e.cyc = cyc;
      e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issueValid = 1'b0;
    end
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rstN === 1'b1 && wbEn === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3", "write without accepted issue", 32'(wbRd), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(wbData == 32'(e.val), e.tag, "converted value", wbData, 32'(e.val));
        chk(wbRd == e.rd, "R2", "destination index", 32'(wbRd), 32'(e.rd));
        chk(cyc - e.cyc == LAT, "R2", "latency", 32'(cyc - e.cyc), 32'(LAT));
        lastData = wbData;
        lastRd   = wbRd;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL R2 watchdog expired: actual %0d expected 0", sb.size());
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    issueValid = 1'b0;
    instr = '0;
    rs1Data = '0;
    repeat (3) @(negedge clk);
    chk(wbEn == 1'b0, "R10", "wbEn in reset", 32'(wbEn), 0);
    chk(wbData == 0, "R10", "wbData in reset", wbData, 0);
    chk(wbRd == 0, "R10", "wbRd in reset", 32'(wbRd), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(wbEn == 1'b0 && wbData == 0, "R10", "after reset", wbData, 0);

    chk(enc(5'd10, 5'd11) == 32'hC2058553, "R1", "encoding", enc(5'd10, 5'd11), 32'hC2058553);

    // exact integers, back-to-back
    issue(1'b1, enc(5'd1, 5'd2), 32'h0000_0000, 1'b1, "R9");
    for (int k = 1; k <= 15; k++)
      issue(1'b1, enc(5'(k), 5'd3), toSingle(real'(k)), 1'b1, "R9");
    idle(4);

    // rounding ties and near-ties
    issue(1'b1, enc(5'd4, 5'd1), toSingle(0.5),   1'b1, "R8");
    issue(1'b1, enc(5'd5, 5'd1), toSingle(1.5),   1'b1, "R8");
    issue(1'b1, enc(5'd6, 5'd1), toSingle(2.5),   1'b1, "R8");
    issue(1'b1, enc(5'd7, 5'd1), toSingle(3.5),   1'b1, "R8");
    issue(1'b1, enc(5'd8, 5'd1), toSingle(14.5),  1'b1, "R8");
    issue(1'b1, enc(5'd9, 5'd1), toSingle(0.49),  1'b1, "R8");
    issue(1'b1, enc(5'd9, 5'd1), toSingle(0.51),  1'b1, "R8");
    issue(1'b1, enc(5'd9, 5'd1), toSingle(7.25),  1'b1, "R8");
    issue(1'b1, enc(5'd9, 5'd1), toSingle(7.75),  1'b1, "R8");
    issue(1'b1, enc(5'd9, 5'd1), toSingle(0.3),   1'b1, "R8");
    idle(4);

    // saturation
    issue(1'b1, enc(5'd12, 5'd1), toSingle(15.49), 1'b1, "R4");
    issue(1'b1, enc(5'd12, 5'd1), toSingle(15.5),  1'b1, "R4");
    issue(1'b1, enc(5'd12, 5'd1), toSingle(16.0),  1'b1, "R4");
    issue(1'b1, enc(5'd12, 5'd1), toSingle(100.0), 1'b1, "R4");
    issue(1'b1, enc(5'd12, 5'd1), 32'h7F7F_FFFF,   1'b1, "R4");
    issue(1'b1, enc(5'd12, 5'd1), 32'h7F80_0000,   1'b1, "R4");
    idle(4);

    // sign, NaN, denormal
    issue(1'b1, enc(5'd13, 5'd1), 32'h8000_0000, 1'b1, "R5");
    issue(1'b1, enc(5'd13, 5'd1), toSingle(-1.0), 1'b1, "R5");
    issue(1'b1, enc(5'd13, 5'd1), toSingle(-20.0), 1'b1, "R5");
    issue(1'b1, enc(5'd13, 5'd1), 32'hFF80_0000, 1'b1, "R5");
    issue(1'b1, enc(5'd14, 5'd1), toSingle(9.0), 1'b1, "R11");
    issue(1'b1, enc(5'd15, 5'd1), 32'h7FC0_0000, 1'b1, "R6");
    issue(1'b1, enc(5'd15, 5'd1), 32'hFFC0_0000, 1'b1, "R6");
    issue(1'b1, enc(5'd15, 5'd1), 32'h7F80_0001, 1'b1, "R6");
    issue(1'b1, enc(5'd16, 5'd1), 32'h0000_0001, 1'b1, "R7");
    issue(1'b1, enc(5'd16, 5'd1), 32'h007F_FFFF, 1'b1, "R7");
    issue(1'b1, enc(5'd17, 5'd1), toSingle(6.0), 1'b1, "R11");
    idle(4);

    // non-matching issues must not write
    issue(1'b1, enc(5'd20, 5'd1), toSingle(5.0), 1'b1, "R11");
    idle(4);
    issue(1'b1, enc(5'd21, 5'd1) ^ 32'h0200_0000, toSingle(3.0), 1'b0, "R3");  // funct7
    issue(1'b1, enc(5'd21, 5'd1) | 32'h0010_0000, toSingle(3.0), 1'b0, "R3");  // rs2
    issue(1'b1, enc(5'd21, 5'd1) | 32'h0000_1000, toSingle(3.0), 1'b0, "R3");  // funct3
    issue(1'b1, enc(5'd21, 5'd1) ^ 32'h0000_0001, toSingle(3.0), 1'b0, "R3");  // opcode
    issue(1'b0, enc(5'd21, 5'd1), toSingle(3.0), 1'b0, "R3");                  // not valid
    idle(LAT + 3);
    chk(wbData == 32'd5, "R3", "data held", wbData, 32'd5);
    chk(wbRd == 5'd20, "R3", "rd held", 32'(wbRd), 32'd20);
    chk(wbData == lastData, "R3", "data matches last write", wbData, lastData);

    idle(4);
    chk(sb.size() == 0, "R2", "outstanding results", 32'(sb.size()), 0);
    chk(wbData[31:4] == 0, "R12", "upper bits", wbData, {28'd0, wbData[3:0]});
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule